// File: doc/BRIEF.md
# Register-list block transfer sequencer

This block carries out a multi-register move between a sixteen-entry general register file and memory. The register file holds data registers D0 to D7 at indexes 0 to 7 and address registers A0 to A7 at indexes 8 to 15. A single start strobe supplies the whole request: a direction (store registers to memory, or load them from memory), an operand size (16-bit word or 32-bit long), an addressing-mode code, a 16-bit selection mask, a precomputed effective address and the number of the address register that serves as the base. Decoding the instruction and computing the effective address are done outside the block, and the register file also lives outside it.

The sequencer goes through the selected registers one at a time. It reads or writes each one through a word-wide memory request/acknowledge port and through separate read and write ports into the register file. When the addressing mode calls for it, the sequencer writes the final working address back to the base register. Finally it reports the number of machine cycles the whole operation would take. The busy output stays high for the whole operation, and done pulses once when the operation ends.

Top module: `regset_xfer`

## Requirements
- R1: For a store with mode code 2 (predecrement), registers are visited from index 15 down to index 0. Mask bit k selects index 15-k, so bit 0 selects A7 and bit 15 selects D0.
- R2: For any other combination of direction and mode, registers are visited from index 0 up to index 15, and mask bit k selects index k.
- R3: The address step is 4 for long transfers and 2 for word transfers. A predecrement store subtracts the step before each register. Every other case adds the step after each register.
- R4: With mode code 1 (postincrement) or mode code 2, the final working address is written to register 8+base after all data transfers. This write therefore takes precedence over a value loaded into that same register.
- R5: A word load is sign-extended from bit 15 to 32 bits before it is written, including when the target is a data register.
- R6: A long store makes two word bus cycles. The first writes bits 15:0 at address+2 and the second writes bits 31:16 at address. A long load reads bits 31:16 at address and then bits 15:0 at address+2.
- R7: The reported cycle count is a base of 8 for a store or 4 for a load, plus a mode extra, plus 4 for prefetch, plus 4 for each acknowledged word bus cycle. The mode extra by code is: 0 register-indirect, 1 and 2 add 0; 3 base+displacement and 4 PC+displacement add 4; 5 base+index and 6 PC+index add 6; 7 absolute short adds 4; 8 absolute long adds 8.
- R8: An all-zero mask makes no bus cycles. It is still charged the overhead cycles, and it still performs the base write-back of R4.
- R9: The busy output rises only after an accepted start and stays high until done. Done is high for exactly one clock. A start seen while busy is ignored.
- R10: A memory request holds its address, direction and write data unchanged until it is acknowledged.
- R11: After reset the block is idle: busy, done, memory request and register write are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| dir_store_i | input | 1 | 1 = registers to memory, 0 = memory to registers |
| long_i | input | 1 | 1 = 32-bit transfers, 0 = 16-bit transfers |
| mode_i | input | 4 | Addressing-mode code (see R7) |
| mask_i | input | 16 | Register selection mask |
| ea_i | input | 32 | Precomputed effective address |
| base_i | input | 3 | Address register number used for write-back |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | 1 = write cycle |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Request acknowledge, one clock |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock end pulse |
| cycles_o | output | 16 | Cycle count of the operation, valid with done |

## Verification
The bench builds the block with its default parameters: sixteen registers, a 32-bit address, 16-bit bus words and a 16-bit cycle counter. With these values every mode code from 0 to 8 can be swept against both directions, both sizes and a set of masks that includes empty, full, and single-bit masks at each end. Acknowledge latency changes from operation to operation, and the base register number rotates. This means every bus address sequence, every sign extension, the write-back collision and every entry of the cycle budget are compared against values the bench computes arithmetically.

// File: rtl/regset_pkg.sv
package regset_pkg;

  typedef enum logic [3:0] {
    AM_IND     = 4'd0,
    AM_POSTINC = 4'd1,
    AM_PREDEC  = 4'd2,
    AM_DISP    = 4'd3,
    AM_PCDISP  = 4'd4,
    AM_INDEX   = 4'd5,
    AM_PCINDEX = 4'd6,
    AM_ABSW    = 4'd7,
    AM_ABSL    = 4'd8
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_NEXT,
    S_FETCH,
    S_BLO,
    S_BHI,
    S_WREG,
    S_WBACK,
    S_FIN
  } seq_e;

endpackage

// File: rtl/regset_pick.sv
// Lowest-set-bit finder over the remaining selection vector.
module regset_pick #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]         vec_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] pos_o,
  output logic [N-1:0]         rest_o
);
  localparam int unsigned PW = $clog2(N);

  logic [N-1:0] first;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_first
      if (g == 0) begin : g_lsb
        assign first[g] = vec_i[g];
      end else begin : g_upper
        assign first[g] = vec_i[g] & ~(|vec_i[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) pos_o = pos_o | PW'(i);
    end
  end

  assign any_o  = |vec_i;
  assign rest_o = vec_i & ~first;

endmodule

// File: rtl/regset_budget.sv
// Fixed overhead charged at start: direction base, mode extra, prefetch.
module regset_budget import regset_pkg::*; #(
  parameter int unsigned CW         = 16,
  parameter int unsigned STORE_BASE = 8,
  parameter int unsigned LOAD_BASE  = 4,
  parameter int unsigned PREFETCH   = 4
) (
  input  logic          store_i,
  input  logic [3:0]    mode_i,
  output logic [CW-1:0] ovh_o
);
  logic [CW-1:0] extra;
  logic [CW-1:0] base;

  always_comb begin
    case (mode_i)
      AM_DISP, AM_PCDISP:   extra = CW'(4);
      AM_INDEX, AM_PCINDEX: extra = CW'(6);
      AM_ABSW:              extra = CW'(4);
      AM_ABSL:              extra = CW'(8);
      default:              extra = '0;
    endcase
  end

  assign base  = store_i ? CW'(STORE_BASE) : CW'(LOAD_BASE);
  assign ovh_o = base + extra + CW'(PREFETCH);

endmodule

// File: rtl/regset_addr.sv
// Working-address arithmetic: step up, step down, and upper-word offset.
module regset_addr #(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 16
) (
  input  logic [AW-1:0] wa_i,
  input  logic          long_i,
  output logic [AW-1:0] up_o,
  output logic [AW-1:0] dn_o,
  output logic [AW-1:0] hi_o
);
  localparam int unsigned HALFB = BW / 8;

  logic [AW-1:0] step;

  assign step = long_i ? AW'(2 * HALFB) : AW'(HALFB);
  assign up_o = wa_i + step;
  assign dn_o = wa_i - step;
  assign hi_o = wa_i + AW'(HALFB);

endmodule

// File: rtl/regset_xfer.sv
module regset_xfer import regset_pkg::*; #(
  parameter int unsigned NREG       = 16,
  parameter int unsigned AW         = 32,
  parameter int unsigned BW         = 16,
  parameter int unsigned CW         = 16,
  parameter int unsigned STORE_BASE = 8,
  parameter int unsigned LOAD_BASE  = 4,
  parameter int unsigned PREFETCH   = 4,
  parameter int unsigned BEAT_COST  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      dir_store_i,
  input  logic                      long_i,
  input  logic [3:0]                mode_i,
  input  logic [NREG-1:0]           mask_i,
  input  logic [AW-1:0]             ea_i,
  input  logic [$clog2(NREG)-2:0]   base_i,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [AW-1:0]             mem_addr_o,
  output logic [BW-1:0]             mem_wdata_o,
  input  logic                      mem_ack_i,
  input  logic [BW-1:0]             mem_rdata_i,
  output logic [$clog2(NREG)-1:0]   rf_raddr_o,
  input  logic [2*BW-1:0]           rf_rdata_i,
  output logic                      rf_we_o,
  output logic [$clog2(NREG)-1:0]   rf_waddr_o,
  output logic [2*BW-1:0]           rf_wdata_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [CW-1:0]             cycles_o
);
  localparam int unsigned IW  = $clog2(NREG);
  localparam int unsigned BIW = IW - 1;
  localparam int unsigned RW  = 2 * BW;

  // state registers
  seq_e            state_q, state_nx;
  logic [NREG-1:0] rem_q,   rem_nx;
  logic [IW-1:0]   idx_q,   idx_nx;
  logic [AW-1:0]   wa_q,    wa_nx;
  logic [RW-1:0]   hold_q,  hold_nx;
  logic [CW-1:0]   cyc_q,   cyc_nx;
  logic            store_q, store_nx;
  logic            long_q,  long_nx;
  logic            desc_q,  desc_nx;
  logic            wb_q,    wb_nx;
  logic [BIW-1:0]  base_q,  base_nx;

  // helper outputs
  logic            pick_any;
  logic [IW-1:0]   pick_pos;
  logic [NREG-1:0] pick_rest;
  logic [CW-1:0]   ovh;
  logic [AW-1:0]   wa_up, wa_dn, wa_hi;
  logic            beat_last;
  logic            seq_en;

  regset_pick #(.N(NREG)) u_pick (
    .vec_i  (rem_q),
    .any_o  (pick_any),
    .pos_o  (pick_pos),
    .rest_o (pick_rest)
  );

  regset_budget #(
    .CW(CW), .STORE_BASE(STORE_BASE), .LOAD_BASE(LOAD_BASE), .PREFETCH(PREFETCH)
  ) u_budget (
    .store_i (dir_store_i),
    .mode_i  (mode_i),
    .ovh_o   (ovh)
  );

  regset_addr #(.AW(AW), .BW(BW)) u_addr (
    .wa_i   (wa_q),
    .long_i (long_q),
    .up_o   (wa_up),
    .dn_o   (wa_dn),
    .hi_o   (wa_hi)
  );

  // A beat that closes the current register: the only word of a word
  // transfer, or the second word of a long transfer.
  assign beat_last = mem_ack_i && ((state_q == S_BHI) || (state_q == S_BLO && !long_q));

  // Clock enable: registers move while busy or when a start is accepted.
  assign seq_en = (state_q != S_IDLE) || start_i;

  // next-state logic
  always_comb begin
    state_nx = state_q;
    rem_nx   = rem_q;
    idx_nx   = idx_q;
    wa_nx    = wa_q;
    hold_nx  = hold_q;
    cyc_nx   = cyc_q;
    store_nx = store_q;
    long_nx  = long_q;
    desc_nx  = desc_q;
    wb_nx    = wb_q;
    base_nx  = base_q;

    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_nx = S_NEXT;
          rem_nx   = mask_i;
          wa_nx    = ea_i;
          cyc_nx   = ovh;
          store_nx = dir_store_i;
          long_nx  = long_i;
          desc_nx  = dir_store_i && (mode_i == AM_PREDEC);
          wb_nx    = (mode_i == AM_PREDEC) || (mode_i == AM_POSTINC);
          base_nx  = base_i;
        end
      end

      S_NEXT: begin
        if (pick_any) begin
          rem_nx   = pick_rest;
          idx_nx   = desc_q ? (IW'(NREG - 1) - pick_pos) : pick_pos;
          state_nx = S_FETCH;
        end else begin
          state_nx = wb_q ? S_WBACK : S_FIN;
        end
      end

      S_FETCH: begin
        if (store_q) hold_nx = rf_rdata_i;
        if (desc_q)  wa_nx   = wa_dn;
        state_nx = S_BLO;
      end

      S_BLO: begin
        if (mem_ack_i) begin
          cyc_nx = cyc_q + CW'(BEAT_COST);
          if (!store_q) begin
            if (long_q) hold_nx = {mem_rdata_i, hold_q[BW-1:0]};
            else        hold_nx = {{BW{mem_rdata_i[BW-1]}}, mem_rdata_i};
          end
          if (long_q) state_nx = S_BHI;
        end
      end

      S_BHI: begin
        if (mem_ack_i) begin
          cyc_nx = cyc_q + CW'(BEAT_COST);
          if (!store_q) hold_nx = {hold_q[RW-1:BW], mem_rdata_i};
        end
      end

      S_WREG:  state_nx = S_NEXT;
      S_WBACK: state_nx = S_FIN;
      S_FIN:   state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase

    if (beat_last) begin
      if (!desc_q) wa_nx = wa_up;
      state_nx = store_q ? S_NEXT : S_WREG;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      idx_q   <= '0;
      wa_q    <= '0;
      hold_q  <= '0;
      cyc_q   <= '0;
      store_q <= 1'b0;
      long_q  <= 1'b0;
      desc_q  <= 1'b0;
      wb_q    <= 1'b0;
      base_q  <= '0;
    end else if (seq_en) begin
      state_q <= state_nx;
      rem_q   <= rem_nx;
      idx_q   <= idx_nx;
      wa_q    <= wa_nx;
      hold_q  <= hold_nx;
      cyc_q   <= cyc_nx;
      store_q <= store_nx;
      long_q  <= long_nx;
      desc_q  <= desc_nx;
      wb_q    <= wb_nx;
      base_q  <= base_nx;
    end
  end

  // memory port: long store puts low word at addr+2 first, long load
  // fetches the upper word at addr first
  always_comb begin
    mem_req_o   = (state_q == S_BLO) || (state_q == S_BHI);
    mem_we_o    = store_q;
    mem_addr_o  = wa_q;
    mem_wdata_o = hold_q[BW-1:0];
    if (state_q == S_BLO) begin
      if (store_q && long_q) mem_addr_o = wa_hi;
    end else if (state_q == S_BHI) begin
      if (store_q) mem_wdata_o = hold_q[RW-1:BW];
      else         mem_addr_o  = wa_hi;
    end
  end

  // register file ports
  assign rf_raddr_o = idx_q;
  assign rf_we_o    = (state_q == S_WREG) || (state_q == S_WBACK);
  assign rf_waddr_o = (state_q == S_WBACK) ? {1'b1, base_q} : idx_q;
  assign rf_wdata_o = (state_q == S_WBACK) ? RW'(wa_q) : hold_q;

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_FIN);
  assign cycles_o = cyc_q;

endmodule

// File: rtl/regset_xfer_chk.sv
module regset_xfer_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 16,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [BW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          rf_we_o,
  input logic [IW-1:0] rf_waddr_o,
  input logic          store_q
);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o)) |-> $past(start_i));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !rf_we_o));

  // R4: during a store the only register write is the base write-back
  a_r4_store_wb_only: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && store_q && rf_we_o) |-> rf_waddr_o[IW-1]);

endmodule

bind regset_xfer regset_xfer_chk #(.AW(AW), .BW(BW), .IW($clog2(NREG))) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .rf_we_o     (rf_we_o),
  .rf_waddr_o  (rf_waddr_o),
  .store_q     (store_q)
);

// File: tb/test_regset_xfer.sv
`timescale 1ns/1ps
module test_regset_xfer;

  logic        clk;
  logic        rst_n;
  logic        start, dir_store, lng;
  logic [3:0]  mode;
  logic [15:0] mask;
  logic [31:0] ea;
  logic [2:0]  base;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we, busy, done;
  logic [15:0] cycles;

  regset_xfer i_regset_xfer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dir_store_i(dir_store),
    .long_i(lng), .mode_i(mode), .mask_i(mask), .ea_i(ea), .base_i(base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .busy_o(busy),
    .done_o(done), .cycles_o(cycles)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic [31:0] rf      [16];
  logic [15:0] mem     [2048];
  logic [31:0] exp_rf  [16];
  logic [15:0] exp_mem [2048];
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [31:0] xlog_addr [64];
  logic        xlog_we   [64];
  int          log_n, xlog_n;
  int          cur_lat, lat_cnt;

  assign rf_rdata = rf[rf_raddr];

  // environment: memory with programmable acknowledge latency, register file
  always @(negedge clk) begin
    if (rf_we) rf[rf_waddr] = rf_wdata;
    mem_ack = 1'b0;
    if (mem_req) begin
      if (lat_cnt >= cur_lat) begin
        mem_ack = 1'b1;
        lat_cnt = 0;
        if (log_n < 64) begin
          log_addr[log_n] = mem_addr;
          log_we[log_n]   = mem_we;
        end
        log_n++;
        if (mem_we) mem[mem_addr[11:1]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[11:1]];
      end else begin
        lat_cnt++;
      end
    end else begin
      lat_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic init_state(input int op);
    for (int i = 0; i < 16; i++)
      rf[i] = (32'(i + 1) * 32'h9E37_79B1) ^ (32'(op) * 32'h85EB_CA6B);
    for (int w = 0; w < 2048; w++)
      mem[w] = 16'((w * 181 + op * 61) ^ (w << 7));
  endtask

  function automatic int mode_extra(input int m);
    case (m)
      3, 4: return 4;
      5, 6: return 6;
      7:    return 4;
      8:    return 8;
      default: return 0;
    endcase
  endfunction

  task automatic xlog(input logic [31:0] a, input bit we);
    if (xlog_n < 64) begin
      xlog_addr[xlog_n] = a;
      xlog_we[xlog_n]   = we;
    end
    xlog_n++;
  endtask

  task automatic run_op(input bit st, input bit lg, input int md, input logic [15:0] mk,
                        input logic [31:0] addr, input int bs, input int lat, input bit spur);
    logic [31:0] wa;
    int          idx, beats, n, bad;
    int          exp_cyc;
    logic [31:0] ba, be;
    bit          predec_st;
    // reference model
    for (int i = 0; i < 16; i++) exp_rf[i] = rf[i];
    for (int w = 0; w < 2048; w++) exp_mem[w] = mem[w];
    xlog_n = 0;
    beats = 0;
    wa = addr;
    predec_st = st && (md == 2);
    for (int k = 0; k < 16; k++) begin
      if (mk[k]) begin
        idx = predec_st ? 15 - k : k;
        if (predec_st) wa = wa - (lg ? 4 : 2);
        if (st) begin
          if (lg) begin
            exp_mem[(wa + 2) >> 1 & 11'h7FF] = exp_rf[idx][15:0];
            exp_mem[wa >> 1 & 11'h7FF]       = exp_rf[idx][31:16];
            xlog(wa + 2, 1'b1); xlog(wa, 1'b1);
            beats += 2;
          end else begin
            exp_mem[wa >> 1 & 11'h7FF] = exp_rf[idx][15:0];
            xlog(wa, 1'b1);
            beats += 1;
          end
        end else begin
          if (lg) begin
            exp_rf[idx] = {exp_mem[wa >> 1 & 11'h7FF], exp_mem[(wa + 2) >> 1 & 11'h7FF]};
            xlog(wa, 1'b0); xlog(wa + 2, 1'b0);
            beats += 2;
          end else begin
            exp_rf[idx] = {{16{exp_mem[wa >> 1 & 11'h7FF][15]}}, exp_mem[wa >> 1 & 11'h7FF]};
            xlog(wa, 1'b0);
            beats += 1;
          end
        end
        if (!predec_st) wa = wa + (lg ? 4 : 2);
      end
    end
    if (md == 1 || md == 2) exp_rf[8 + bs] = wa;
    exp_cyc = (st ? 8 : 4) + mode_extra(md) + 4 + 4 * beats;

    // drive
    log_n = 0;
    cur_lat = lat;
    dir_store = st; lng = lg; mode = 4'(md); mask = mk; ea = addr; base = 3'(bs);
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (spur) begin
      @(negedge clk); #1;
      dir_store = ~st; mask = ~mk; ea = addr + 32'h40; mode = 4'd8;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk); #1;
      n++;
    end
    chk(done, "R9", "operation reached done", 32'(done), 32'd1);
    chk(cycles == 16'(exp_cyc), "R7 R8", $sformatf("cycle count st=%0d lg=%0d mode=%0d mask=%h", st, lg, md, mk),
        32'(cycles), 32'(exp_cyc));
    @(negedge clk); #1;
    chk(!done && !busy, "R9", "done one clock then idle", {30'd0, busy, done}, 32'd0);

    bad = 0; ba = '0; be = '0;
    for (int i = 0; i < 16; i++)
      if (rf[i] !== exp_rf[i]) begin
        if (bad == 0) begin ba = rf[i]; be = exp_rf[i]; end
        bad++;
      end
    chk(bad == 0, "R1 R2 R4 R5", $sformatf("register file st=%0d lg=%0d mode=%0d mask=%h", st, lg, md, mk), ba, be);

    bad = 0;
    for (int w = 0; w < 2048; w++)
      if (mem[w] !== exp_mem[w]) begin
        if (bad == 0) begin ba = 32'(mem[w]); be = 32'(exp_mem[w]); end
        bad++;
      end
    chk(bad == 0, "R1 R2 R3 R6", $sformatf("memory image st=%0d lg=%0d mode=%0d mask=%h", st, lg, md, mk), ba, be);

    bad = (log_n != xlog_n) ? 1 : 0;
    ba = 32'(log_n); be = 32'(xlog_n);
    if (bad == 0)
      for (int j = 0; j < log_n && j < 64; j++)
        if (bad == 0 && (log_addr[j] !== xlog_addr[j] || log_we[j] !== xlog_we[j])) begin
          bad = 1; ba = log_addr[j]; be = xlog_addr[j];
        end
    chk(bad == 0, "R3 R6 R8 R10", $sformatf("bus sequence st=%0d lg=%0d mode=%0d mask=%h", st, lg, md, mk), ba, be);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] masks [5];
    int          op;
    rst_n = 1'b0; start = 1'b0; dir_store = 1'b0; lng = 1'b0; mode = '0;
    mask = '0; ea = '0; base = '0; mem_ack = 1'b0; mem_rdata = '0;
    cur_lat = 0; lat_cnt = 0; log_n = 0; xlog_n = 0;
    init_state(0);
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !mem_req && !rf_we, "R11", "idle during reset",
        {28'd0, busy, done, mem_req, rf_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !done && !mem_req && !rf_we, "R11", "idle after reset",
        {28'd0, busy, done, mem_req, rf_we}, 32'd0);

    op = 0;
    for (int st = 0; st < 2; st++)
      for (int lg = 0; lg < 2; lg++)
        for (int md = 0; md < 9; md++) begin
          masks[0] = 16'h0000;
          masks[1] = 16'hFFFF;
          masks[2] = 16'h0001;
          masks[3] = 16'h8000;
          masks[4] = 16'((op * 16'h2F1B) ^ 16'hA5C3);
          for (int m = 0; m < 5; m++) begin
            init_state(op);
            run_op(st[0], lg[0], md, masks[m], 32'h500 + 32'((op % 4) * 32), op % 8, op % 3, 1'b0);
            op++;
          end
        end

    // R9: a second start during a busy operation is ignored
    init_state(500);
    run_op(1'b1, 1'b1, 2, 16'hFFFF, 32'h600, 7, 1, 1'b1);
    init_state(501);
    run_op(1'b0, 1'b0, 1, 16'h00F0, 32'h480, 3, 0, 1'b1);

    // R4: postincrement load that also selects its own base register
    init_state(502);
    run_op(1'b0, 1'b1, 1, 16'h0400, 32'h520, 2, 0, 1'b0);
    chk(rf[10] == 32'h524, "R4", "write-back wins over loaded base", rf[10], 32'h524);

    // R5: negative word into a data register
    init_state(503);
    mem[32'h540 >> 1] = 16'h8001;
    run_op(1'b0, 1'b0, 0, 16'h0001, 32'h540, 0, 2, 1'b0);
    chk(rf[0] == 32'hFFFF_8001, "R5", "sign-extended word load", rf[0], 32'hFFFF_8001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule